// File: doc/BRIEF.md
# Timer Count-Enable Clock Select

This block decides when a timer counter may advance. It turns a 3-bit select code into a count-enable pulse that lasts one system clock. The code can stop counting, let the counter run on every system clock, divide the system clock by a fixed power of two, or follow the edges of an external clock pin. The counter itself sits outside this block. It increments on every system clock in which `count_tick` is high.

One shared free-running 10-bit prescaler serves all the divided ratios. A divided tick is raised when the low bits that the chosen ratio uses roll over to zero. The external pin passes through a two-flop synchronizer before its edges are detected. The pin is sampled whatever its direction, so a timer can count transitions that its own logic drives onto the pin. Because of the synchronizer, the pin must toggle at less than half the system clock rate. A prescaler clear restarts the shared counter, so the next divided tick comes one full period after the clear.

Top module: `clksel_tick_gen`

## Requirements
- R1: With code 000 (stop), `count_tick` stays low, whatever the pin and the prescaler do.
- R2: With code 001, `count_tick` is high in every clock cycle, one cycle after the code is applied, and `psc_clear` has no effect on it.
- R3: Codes 010, 011, 100 and 101 give exactly one tick every 8, 64, 256 and 1024 system clocks. After a prescaler clear, the first tick appears at the N-th clock edge after the clearing edge, where N is the ratio.
- R4: Code 110 gives one tick for each falling edge of `ext_pin`, and no tick for a rising edge.
- R5: Code 111 gives one tick for each rising edge of `ext_pin`, and no tick for a falling edge.
- R6: An external edge that is set up before clock edge A raises `count_tick` after the third clock edge counted from A, for exactly one cycle. Outside such an edge, the external codes give no tick.
- R7: On a clock edge where `psc_clear` is high, the divided codes give no tick, and the shared prescaler restarts from zero.
- R8: A new select code applies from the next clock edge. Switching between divided ratios adds no extra tick: the next tick follows the new ratio, counted by the shared prescaler.
- R9: Under a divided code that does not change, `count_tick` is never high in two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_sel | input | 3 | Clock select code: 000 stop, 001 /1, 010 /8, 011 /64, 100 /256, 101 /1024, 110 pin falling edge, 111 pin rising edge |
| ext_pin | input | 1 | External clock pin level, sampled regardless of pin direction |
| psc_clear | input | 1 | Synchronous clear of the shared prescaler |
| count_tick | output | 1 | One-cycle count-enable pulse to the timer counter |

## Verification
The hardest case to reach is switching the ratio in the middle of a period. The shared prescaler keeps running through the switch, so the position of the next tick depends on a count that the ports cannot show. The stimulus first clears the prescaler to set a known phase, then changes from /8 to /64 after five clocks. The next tick must then arrive exactly at clock 64 after the clear, with none at clock 8. The external pin is checked edge by edge against the fixed three-clock latency of the synchronizer.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

  typedef enum logic [2:0] {
    CS_STOP     = 3'd0,
    CS_DIV1     = 3'd1,
    CS_DIV8     = 3'd2,
    CS_DIV64    = 3'd3,
    CS_DIV256   = 3'd4,
    CS_DIV1024  = 3'd5,
    CS_EXT_FALL = 3'd6,
    CS_EXT_RISE = 3'd7
  } cs_code_e;

  localparam int NUM_TAPS = 4;
  localparam int FIRST_TAP_CODE = 2;

  // log2 of the division ratio for tap index idx
  function automatic int tap_shift(input int idx);
    case (idx)
      0:       return 3;
      1:       return 6;
      2:       return 8;
      default: return 10;
    endcase
  endfunction

  // true when the low n bits of v are all ones (next increment rolls them to zero)
  function automatic logic low_bits_full(input logic [31:0] v, input int n);
    logic [31:0] mask;
    mask = (32'd1 << n) - 32'd1;
    return (v & mask) == mask;
  endfunction

  function automatic logic is_divided(input logic [2:0] code);
    return (code >= 3'(CS_DIV8)) && (code <= 3'(CS_DIV1024));
  endfunction

  function automatic int tap_index(input logic [2:0] code);
    return int'(code) - FIRST_TAP_CODE;
  endfunction

endpackage

// File: rtl/clksel_prescaler.sv
module clksel_prescaler
  import clksel_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int NTAPS = NUM_TAPS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  output logic [NTAPS-1:0] tap_roll
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  for (genvar gi = 0; gi < NTAPS; gi++) begin : g_tap
    assign tap_roll[gi] = !clear && low_bits_full(32'(cnt), tap_shift(gi));
  end

endmodule

// File: rtl/clksel_edge_sync.sv
module clksel_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);

  // STAGES synchronizer flops followed by one history flop
  logic [STAGES:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-1:0], pin};
  end

  assign rise =  shreg[STAGES-1] && !shreg[STAGES];
  assign fall = !shreg[STAGES-1] &&  shreg[STAGES];

endmodule

// File: rtl/clksel_tick_select.sv
module clksel_tick_select
  import clksel_pkg::*;
#(
  parameter int NTAPS = NUM_TAPS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       sel,
  input  logic [NTAPS-1:0] tap_roll,
  input  logic             ext_rise,
  input  logic             ext_fall,
  output logic             tick
);

  logic tick_d;

  always_comb begin
    tick_d = 1'b0;
    unique case (cs_code_e'(sel))
      CS_STOP:     tick_d = 1'b0;
      CS_DIV1:     tick_d = 1'b1;
      CS_DIV8,
      CS_DIV64,
      CS_DIV256,
      CS_DIV1024:  tick_d = tap_roll[tap_index(sel)];
      CS_EXT_FALL: tick_d = ext_fall;
      CS_EXT_RISE: tick_d = ext_rise;
      default:     tick_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick <= 1'b0;
    else        tick <= tick_d;
  end

endmodule

// File: rtl/clksel_tick_gen.sv
module clksel_tick_gen
  import clksel_pkg::*;
#(
  parameter int PSC_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] cs_sel,
  input  logic       ext_pin,
  input  logic       psc_clear,
  output logic       count_tick
);

  logic [NUM_TAPS-1:0] tap_roll;
  logic                ext_rise;
  logic                ext_fall;

  clksel_prescaler #(.CNT_W(PSC_W), .NTAPS(NUM_TAPS)) u_psc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (psc_clear),
    .tap_roll (tap_roll)
  );

  clksel_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   (ext_pin),
    .rise  (ext_rise),
    .fall  (ext_fall)
  );

  clksel_tick_select #(.NTAPS(NUM_TAPS)) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (cs_sel),
    .tap_roll (tap_roll),
    .ext_rise (ext_rise),
    .ext_fall (ext_fall),
    .tick     (count_tick)
  );

endmodule

// File: rtl/clksel_tick_gen_chk.sv
module clksel_tick_gen_chk
  import clksel_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] cs_sel,
  input logic       psc_clear,
  input logic       count_tick,
  input logic       ext_rise,
  input logic       ext_fall
);

  assert_stop_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_sel == 3'd0) |=> !count_tick);

  assert_div1_every_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_sel == 3'd1) |=> count_tick);

  assert_fall_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_sel == 3'd6 && ext_fall) |=> count_tick);

  assert_rise_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_sel == 3'd7 && ext_rise) |=> count_tick);

  assert_ext_only_edges_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_sel >= 3'd6 && !ext_rise && !ext_fall) |=> !count_tick);

  assert_edge_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ext_rise, ext_fall}));

  assert_clear_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (psc_clear && is_divided(cs_sel)) |=> !count_tick);

  assert_divided_narrow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_divided(cs_sel) && $stable(cs_sel) && count_tick) |=> !count_tick);

endmodule

bind clksel_tick_gen clksel_tick_gen_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_sel     (cs_sel),
  .psc_clear  (psc_clear),
  .count_tick (count_tick),
  .ext_rise   (ext_rise),
  .ext_fall   (ext_fall)
);

// File: tb/sim_clksel_tick_gen.sv
`timescale 1ns/1ps
module sim_clksel_tick_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cs_sel = 3'd0;
  logic       ext_pin = 1'b0;
  logic       psc_clear = 1'b0;
  logic       count_tick;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  clksel_tick_gen u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_sel     (cs_sel),
    .ext_pin    (ext_pin),
    .psc_clear  (psc_clear),
    .count_tick (count_tick)
  );

  task automatic chk(input logic got, input logic exp, input string req, input int at);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s at step %0d: count_tick=%b expected %b", req, at, got, exp);
    end
  endtask

  task automatic sample();
    @(posedge clk);
    #2;
  endtask

  task automatic t_reset();
    #2 chk(count_tick, 1'b0, "R1 reset", 0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    sample();
    chk(count_tick, 1'b0, "R1 after reset", 1);
  endtask

  task automatic t_stop();
    @(negedge clk) begin cs_sel = 3'd1; psc_clear = 1'b0; end
    for (int k = 1; k <= 20; k++) begin
      sample(); chk(count_tick, 1'b1, "R2 every clock", k);
    end
    @(negedge clk) psc_clear = 1'b1;
    sample(); chk(count_tick, 1'b1, "R2 clear ignored", 0);
    @(negedge clk) begin psc_clear = 1'b0; cs_sel = 3'd0; end
    for (int k = 1; k <= 2100; k++) begin
      if (k % 5 == 0) ext_pin = ~ext_pin;
      sample(); chk(count_tick, 1'b0, "R1 stopped", k);
    end
    ext_pin = 1'b0;
  endtask

  task automatic t_div(input logic [2:0] code, input int ratio);
    @(negedge clk) begin cs_sel = code; psc_clear = 1'b1; end
    sample(); chk(count_tick, 1'b0, "R7 clear edge", 0);
    @(negedge clk) psc_clear = 1'b0;
    for (int k = 1; k <= 3 * ratio; k++) begin
      sample(); chk(count_tick, (k % ratio) == 0, "R3 divided period", k);
    end
  endtask

  task automatic t_clear_restart();
    @(negedge clk) begin cs_sel = 3'd2; psc_clear = 1'b1; end
    sample();
    @(negedge clk) psc_clear = 1'b0;
    repeat (5) sample();
    @(negedge clk) psc_clear = 1'b1;
    sample(); chk(count_tick, 1'b0, "R7 mid-period clear", 0);
    @(negedge clk) psc_clear = 1'b0;
    for (int k = 1; k <= 16; k++) begin
      sample(); chk(count_tick, (k % 8) == 0, "R7 restart full period", k);
    end
  endtask

  task automatic t_switch();
    @(negedge clk) begin cs_sel = 3'd2; psc_clear = 1'b1; end
    sample();
    @(negedge clk) psc_clear = 1'b0;
    for (int k = 1; k <= 5; k++) begin
      sample(); chk(count_tick, 1'b0, "R8 before switch", k);
    end
    @(negedge clk) cs_sel = 3'd3;
    for (int k = 6; k <= 70; k++) begin
      sample(); chk(count_tick, k == 64, "R8 switch /8 to /64", k);
    end
  endtask

  task automatic t_ext(input logic [2:0] code, input logic active_rise);
    @(negedge clk) begin ext_pin = 1'b0; cs_sel = code; end
    repeat (6) sample();
    @(negedge clk) ext_pin = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      sample();
      chk(count_tick, active_rise && k == 3, active_rise ? "R5 rising tick" : "R4 rising ignored", k);
    end
    @(negedge clk) ext_pin = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      sample();
      chk(count_tick, !active_rise && k == 3, active_rise ? "R5 falling ignored" : "R4 falling tick", k);
    end
  endtask

  task automatic t_ext_train();
    int seen;
    seen = 0;
    @(negedge clk) begin ext_pin = 1'b0; cs_sel = 3'd6; end
    repeat (6) sample();
    for (int k = 1; k <= 80; k++) begin
      @(negedge clk) if (k % 4 == 0) ext_pin = ~ext_pin;
      sample();
      if (count_tick) seen++;
    end
    repeat (6) begin sample(); if (count_tick) seen++; end
    chk(seen == 10, 1'b1, "R6 one tick per falling edge", seen);
  endtask

  initial begin
    t_reset();
    t_stop();
    t_div(3'd2, 8);
    t_div(3'd3, 64);
    t_div(3'd4, 256);
    t_div(3'd5, 1024);
    t_clear_restart();
    t_switch();
    t_ext(3'd7, 1'b1);
    t_ext(3'd6, 1'b0);
    t_ext_train();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run hung, done=%b expected 1", done);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule